// File: doc/BRIEF.md
# Pixel Format Packer with Alpha Control

The block takes a stream of 8-bit-per-channel pixels and repacks them into the byte layout of a chosen output format. It produces a stream of 32-bit words with one write strobe per byte, for a memory writer downstream. Sixteen-bit layouts (4444 and 565), 24-bit layouts (888) and 32-bit layouts (8888) are available in several channel orders. The alpha channel can be passed through, inverted, or replaced by a constant. A 4-bit store mask gates each byte lane of every output word.

Pixels arrive on a valid/ready interface together with an end-of-line marker. Words leave on a valid/ready interface. The format code and the alpha and mask controls are expected to be held steady for the whole of a line. Pixels may pack into a word several at a time, or straddle a word boundary. At the end of a line, a partly filled word is sent with strobes only for the bytes it holds.

Top module: `pixfmt_packer`

## Requirements
- R1: After reset, `out_valid` is 0. With a supported format selected, `in_ready` is 1 and `fmt_err` is 0.
- R2: The 32-bit codes are 12 {A,B,G,R}, 13 {A,R,G,B}, 14 {B,G,R,A} and 15 {R,G,B,A}. Each is written from byte 3 down to byte 0, and each pixel fills one whole word. The input pixel is `{A[31:24], R[23:16], G[15:8], B[7:0]}`.
- R3: The 16-bit codes are 0 {A,B,G,R}, 1 {A,R,G,B}, 2 {B,G,R,A} and 3 {R,G,B,A}, using the upper nibble of each channel. Code 6 is {B5,G6,R5} and code 7 is {R5,G6,B5}. Each 565 field is the upper bits of its channel. All are listed from the most significant bit down.
- R4: In the 16-bit formats, two pixels share one word, and the earlier pixel occupies bits 15:0.
- R5: Code 8 is {B,G,R} and code 9 is {R,G,B}, 3 bytes each, with the last letter in the lowest byte. Bytes are packed back to back across word boundaries, so four pixels make exactly three words.
- R6: With `alpha_keep`=1, the stored alpha is the pixel alpha, complemented when `alpha_inv`=1. With `alpha_keep`=0, every alpha bit is the complement of `alpha_inv`.
- R7: `out_strb` bit i covers `out_data[8i+7:8i]`. Its value is the AND of `byte_mask` bit i and whether that byte holds pixel data.
- R8: When `in_last` is accepted, any partly filled word is emitted with strobes set for the low filled bytes only. If that pixel both completes a word and leaves a remainder, two words are emitted. `in_ready` stays low until the second word has been sent.
- R9: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_strb` hold, and no input pixel is lost.
- R10: For codes 4, 5, 10 and 11, `fmt_err`=1. Input pixels are accepted and dropped, and no word is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_code | input | 4 | Output format selector |
| alpha_keep | input | 1 | Store alpha from the pixel (1) or a constant fill (0) |
| alpha_inv | input | 1 | Inverts stored alpha, or picks the fill value |
| byte_mask | input | 4 | Per-lane store enable |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pixel | input | 32 | ARGB pixel, 8 bits per channel |
| in_last | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Packed output word |
| out_strb | output | 4 | Byte write strobes |
| fmt_err | output | 1 | Unsupported format selected |

## Verification
The bench's first concern is channel order. A swapped pair of channels, or a lane read from the wrong end, changes a word that the format table predicts exactly. The pixel used gives each channel a distinct nibble, so packing nibbles or 565 fields from the low bits of a channel also shows as a wrong value.

The 24-bit tests cover both ways a line can end on a 3-byte format. In one, four pixels must make exactly three words; a packer that drops or duplicates the leftover bytes gives the wrong count. In the other, a two-pixel line needs a full word followed by a 2-byte flush; if the pending state is lost, the flush word is missing or carries the wrong strobes.

Back-pressure checks that a stalled word holds steady and that the next pixel waits. Bad format codes must produce no words at all.

// File: rtl/pf_pkg.sv
// Package: shared sizes, format codes and strobe helper for the pixel packer.
// Assumes 8-bit channels and 32-bit output words.
package pf_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int ACC_W      = BYTE_W * (WORD_BYTES - 1);
    localparam int COMB_W     = ACC_W + WORD_W;
    localparam int LEN_W      = 3;

    typedef enum logic [3:0] {
        FMT_ABGR4444 = 4'd0,
        FMT_ARGB4444 = 4'd1,
        FMT_BGRA4444 = 4'd2,
        FMT_RGBA4444 = 4'd3,
        FMT_BGR565   = 4'd6,
        FMT_RGB565   = 4'd7,
        FMT_BGR888   = 4'd8,
        FMT_RGB888   = 4'd9,
        FMT_ABGR8888 = 4'd12,
        FMT_ARGB8888 = 4'd13,
        FMT_BGRA8888 = 4'd14,
        FMT_RGBA8888 = 4'd15
    } fmt_e;

    // Strobe pattern with the lowest n lanes set
    function automatic logic [WORD_BYTES-1:0] low_strb(input logic [LEN_W-1:0] n);
        logic [WORD_BYTES-1:0] s;
        s = '0;
        for (int i = 0; i < WORD_BYTES; i++)
            if (LEN_W'(i) < n) s[i] = 1'b1;
        return s;
    endfunction
endpackage

// File: rtl/pf_format_map.sv
// Format map: turns one ARGB pixel into its output bytes (byte 0 in bits 7:0)
// and a byte count. Purely combinational. Unsupported codes give length 0
// and fmt_ok low.
module pf_format_map
    import pf_pkg::*;
(
    input  logic [WORD_W-1:0] pixel,
    input  logic [3:0]        fmt,
    input  logic              alpha_keep,
    input  logic              alpha_inv,
    output logic [WORD_W-1:0] pix_bytes,
    output logic [LEN_W-1:0]  pix_len,
    output logic              fmt_ok
);
    logic [BYTE_W-1:0] ch_a, ch_r, ch_g, ch_b, a_eff;

    assign ch_a = pixel[31:24];
    assign ch_r = pixel[23:16];
    assign ch_g = pixel[15:8];
    assign ch_b = pixel[7:0];

    // Alpha source: pixel value (optionally inverted) or constant fill
    always_comb a_eff = alpha_keep ? (alpha_inv ? ~ch_a : ch_a) : {BYTE_W{~alpha_inv}};

    // Layout selection per format code
    always_comb begin
        pix_bytes = '0;
        pix_len   = '0;
        fmt_ok    = 1'b1;
        case (fmt)
            FMT_ABGR4444: begin pix_bytes[15:0] = {a_eff[7:4], ch_b[7:4], ch_g[7:4], ch_r[7:4]}; pix_len = 3'd2; end
            FMT_ARGB4444: begin pix_bytes[15:0] = {a_eff[7:4], ch_r[7:4], ch_g[7:4], ch_b[7:4]}; pix_len = 3'd2; end
            FMT_BGRA4444: begin pix_bytes[15:0] = {ch_b[7:4], ch_g[7:4], ch_r[7:4], a_eff[7:4]}; pix_len = 3'd2; end
            FMT_RGBA4444: begin pix_bytes[15:0] = {ch_r[7:4], ch_g[7:4], ch_b[7:4], a_eff[7:4]}; pix_len = 3'd2; end
            FMT_BGR565:   begin pix_bytes[15:0] = {ch_b[7:3], ch_g[7:2], ch_r[7:3]}; pix_len = 3'd2; end
            FMT_RGB565:   begin pix_bytes[15:0] = {ch_r[7:3], ch_g[7:2], ch_b[7:3]}; pix_len = 3'd2; end
            FMT_BGR888:   begin pix_bytes[23:0] = {ch_b, ch_g, ch_r}; pix_len = 3'd3; end
            FMT_RGB888:   begin pix_bytes[23:0] = {ch_r, ch_g, ch_b}; pix_len = 3'd3; end
            FMT_ABGR8888: begin pix_bytes = {a_eff, ch_b, ch_g, ch_r}; pix_len = 3'd4; end
            FMT_ARGB8888: begin pix_bytes = {a_eff, ch_r, ch_g, ch_b}; pix_len = 3'd4; end
            FMT_BGRA8888: begin pix_bytes = {ch_b, ch_g, ch_r, a_eff}; pix_len = 3'd4; end
            FMT_RGBA8888: begin pix_bytes = {ch_r, ch_g, ch_b, a_eff}; pix_len = 3'd4; end
            default:      fmt_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/pf_byte_packer.sv
// Byte packer: appends each pixel's bytes to a carry register holding up to
// three bytes. Full words go to the output register. At end of line, the
// remainder is flushed, taking an extra cycle when a word and a remainder
// are both due. Assumes take is only raised when out_free is high.
module pf_byte_packer
    import pf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take,
    input  logic [WORD_W-1:0]     pix_bytes,
    input  logic [LEN_W-1:0]      pix_len,
    input  logic                  pix_last,
    input  logic [WORD_BYTES-1:0] byte_mask,
    input  logic                  out_ready,
    output logic                  out_free,
    output logic                  flush_pend,
    output logic                  out_valid,
    output logic [WORD_W-1:0]     out_data,
    output logic [WORD_BYTES-1:0] out_strb
);
    logic [ACC_W-1:0]  acc_q;
    logic [LEN_W-1:0]  fill_q;
    logic              flush_q;
    logic [COMB_W-1:0] combined;
    logic [LEN_W-1:0]  total;

    assign out_free   = !out_valid || out_ready;
    assign flush_pend = flush_q;

    // Merge carried bytes with the new pixel placed above them
    always_comb begin
        combined = {{WORD_W{1'b0}}, acc_q}
                 | ({{ACC_W{1'b0}}, pix_bytes} << {fill_q, 3'b000});
        total    = fill_q + pix_len;
    end

    // Carry, flush and output-register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_strb  <= '0;
            acc_q     <= '0;
            fill_q    <= '0;
            flush_q   <= 1'b0;
        end else begin
            if (out_free) out_valid <= 1'b0;
            if (flush_q && out_free) begin
                out_valid <= 1'b1;
                out_data  <= {{BYTE_W{1'b0}}, acc_q};
                out_strb  <= low_strb(fill_q) & byte_mask;
                acc_q     <= '0;
                fill_q    <= '0;
                flush_q   <= 1'b0;
            end else if (take) begin
                if (total >= LEN_W'(WORD_BYTES)) begin
                    out_valid <= 1'b1;
                    out_data  <= combined[WORD_W-1:0];
                    out_strb  <= byte_mask;
                    acc_q     <= combined[COMB_W-1:WORD_W];
                    fill_q    <= total - LEN_W'(WORD_BYTES);
                    flush_q   <= pix_last && (total != LEN_W'(WORD_BYTES));
                end else if (pix_last) begin
                    out_valid <= 1'b1;
                    out_data  <= combined[WORD_W-1:0];
                    out_strb  <= low_strb(total) & byte_mask;
                    acc_q     <= '0;
                    fill_q    <= '0;
                end else begin
                    acc_q     <= combined[ACC_W-1:0];
                    fill_q    <= total;
                end
            end
        end
    end

    // R9: a stalled word stays put
    a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_strb));
    // R7: no strobe outside the store mask
    a_r7_strb_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_strb & ~byte_mask) == '0);
    // R8: a pending flush always carries bytes
    a_r8_flush_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        flush_q |-> fill_q != '0);
endmodule

// File: rtl/pixfmt_packer.sv
// Top: pixel-to-word format packer. Maps each accepted pixel to its bytes,
// then packs them into strobed 32-bit words. Pixels under an unsupported
// format code are accepted and dropped. Controls are assumed steady per line.
module pixfmt_packer
    import pf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3:0]            fmt_code,
    input  logic                  alpha_keep,
    input  logic                  alpha_inv,
    input  logic [WORD_BYTES-1:0] byte_mask,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [WORD_W-1:0]     in_pixel,
    input  logic                  in_last,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [WORD_W-1:0]     out_data,
    output logic [WORD_BYTES-1:0] out_strb,
    output logic                  fmt_err
);
    logic [WORD_W-1:0] pix_bytes;
    logic [LEN_W-1:0]  pix_len;
    logic              fmt_ok, out_free, flush_pend, take;

    pf_format_map u_map (
        .pixel      (in_pixel),
        .fmt        (fmt_code),
        .alpha_keep (alpha_keep),
        .alpha_inv  (alpha_inv),
        .pix_bytes  (pix_bytes),
        .pix_len    (pix_len),
        .fmt_ok     (fmt_ok)
    );

    // Input handshake: drop pixels on bad codes, otherwise wait for room
    always_comb begin
        fmt_err  = !fmt_ok;
        in_ready = fmt_err || (out_free && !flush_pend);
        take     = in_valid && in_ready && fmt_ok;
    end

    pf_byte_packer u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .pix_bytes  (pix_bytes),
        .pix_len    (pix_len),
        .pix_last   (in_last),
        .byte_mask  (byte_mask),
        .out_ready  (out_ready),
        .out_free   (out_free),
        .flush_pend (flush_pend),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_strb   (out_strb)
    );

    // R8: no new pixel while the flush word is owed
    a_r8_flush_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pend && !fmt_err |-> !in_ready);
    // R10: a bad code starts no word
    a_r10_bad_code_silent: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err && !out_valid && !flush_pend |=> !out_valid);
endmodule

// File: tb/pixfmt_packer_bench.sv
module pixfmt_packer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  fmt_code = 4'd13;
    logic        alpha_keep = 1'b1, alpha_inv = 1'b0;
    logic [3:0]  byte_mask = 4'hF;
    logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
    logic [31:0] in_pixel = '0;
    logic        in_ready, out_valid, fmt_err;
    logic [31:0] out_data;
    logic [3:0]  out_strb;

    int checks = 0, errors = 0;
    int cap_n = 0;
    logic [31:0] cap_w [64];
    logic [3:0]  cap_s [64];

    always #5 clk = ~clk;

    pixfmt_packer u_pixfmt_packer (.*);

    typedef struct packed {
        logic [3:0]  f;
        logic        k;
        logic        i;
        logic [31:0] p;
        logic [31:0] w;
        logic [3:0]  s;
    } vec_t;

    // Pixel C3 5A 96 2D (A,R,G,B); one-pixel lines. R2 8888 orders, R3 16-bit fields, R5 888, R6 alpha modes
    localparam vec_t VECS [13] = '{
        '{4'd13, 1'b1, 1'b0, 32'hC35A962D, 32'hC35A962D, 4'hF},
        '{4'd12, 1'b1, 1'b0, 32'hC35A962D, 32'hC32D965A, 4'hF},
        '{4'd14, 1'b1, 1'b1, 32'hC35A962D, 32'h2D965A3C, 4'hF},
        '{4'd15, 1'b0, 1'b0, 32'hC35A962D, 32'h5A962DFF, 4'hF},
        '{4'd13, 1'b0, 1'b1, 32'hC35A962D, 32'h005A962D, 4'hF},
        '{4'd0,  1'b1, 1'b0, 32'hC35A962D, 32'h0000C295, 4'h3},
        '{4'd1,  1'b1, 1'b1, 32'hC35A962D, 32'h00003592, 4'h3},
        '{4'd2,  1'b0, 1'b0, 32'hC35A962D, 32'h0000295F, 4'h3},
        '{4'd3,  1'b1, 1'b0, 32'hC35A962D, 32'h0000592C, 4'h3},
        '{4'd7,  1'b1, 1'b0, 32'hC35A962D, 32'h00005CA5, 4'h3},
        '{4'd6,  1'b1, 1'b0, 32'hC35A962D, 32'h00002CAB, 4'h3},
        '{4'd9,  1'b1, 1'b0, 32'hC35A962D, 32'h005A962D, 4'h7},
        '{4'd8,  1'b1, 1'b0, 32'hC35A962D, 32'h002D965A, 4'h7}
    };

    // Capture accepted output words
    always @(negedge clk)
        if (rst_n && out_valid && out_ready && cap_n < 64) begin
            cap_w[cap_n] = out_data;
            cap_s[cap_n] = out_strb;
            cap_n++;
        end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Offer one pixel from a falling edge until it is taken
    task automatic send(input logic [31:0] p, input logic last);
        in_valid = 1'b1; in_pixel = p; in_last = last;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_word(input int idx, input logic [31:0] w, input logic [3:0] s, input string req);
        chk(cap_w[idx] == w, req, cap_w[idx], w);
        chk(cap_s[idx] == s, req, {28'b0, cap_s[idx]}, {28'b0, s});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 out_valid", {31'b0, out_valid}, 0);
        chk(in_ready == 1'b1, "R1 in_ready", {31'b0, in_ready}, 1);
        chk(fmt_err == 1'b0, "R1 fmt_err", {31'b0, fmt_err}, 0);

        // Table walk
        for (int v = 0; v < 13; v++) begin
            fmt_code = VECS[v].f; alpha_keep = VECS[v].k; alpha_inv = VECS[v].i;
            base = cap_n;
            send(VECS[v].p, 1'b1);
            idle(4);
            chk(cap_n == base + 1, $sformatf("R2/R3/R5/R6 vec %0d count", v), cap_n - base, 1);
            expect_word(base, VECS[v].w, VECS[v].s, $sformatf("R2/R3/R5/R6 vec %0d", v));
        end

        // R4 two 565 pixels, first in low half
        fmt_code = 4'd7; alpha_keep = 1'b1; alpha_inv = 1'b0;
        base = cap_n;
        send(32'h00FF0000, 1'b0);
        send(32'h000000FF, 1'b1);
        idle(4);
        chk(cap_n == base + 1, "R4 count", cap_n - base, 1);
        expect_word(base, 32'h001FF800, 4'hF, "R4 pair order");

        // R5 four 888 pixels make three words
        fmt_code = 4'd9;
        base = cap_n;
        send(32'h00112233, 1'b0);
        send(32'h00445566, 1'b0);
        send(32'h00778899, 1'b0);
        send(32'h00AABBCC, 1'b1);
        idle(4);
        chk(cap_n == base + 3, "R5 count", cap_n - base, 3);
        expect_word(base,     32'h66112233, 4'hF, "R5 w0");
        expect_word(base + 1, 32'h88994455, 4'hF, "R5 w1");
        expect_word(base + 2, 32'hAABBCC77, 4'hF, "R5 w2");

        // R8 two-pixel 888 line: full word then 2-byte flush
        base = cap_n;
        send(32'h00112233, 1'b0);
        send(32'h00445566, 1'b1);
        idle(5);
        chk(cap_n == base + 2, "R8 count", cap_n - base, 2);
        expect_word(base,     32'h66112233, 4'hF, "R8 full word");
        expect_word(base + 1, 32'h00004455, 4'h3, "R8 flush word");

        // R7 store mask gating
        fmt_code = 4'd13; byte_mask = 4'h5;
        base = cap_n;
        send(32'hC35A962D, 1'b1);
        idle(4);
        expect_word(base, 32'hC35A962D, 4'h5, "R7 mask 8888");
        fmt_code = 4'd7; byte_mask = 4'hE;
        base = cap_n;
        send(32'hC35A962D, 1'b1);
        idle(4);
        expect_word(base, 32'h00005CA5, 4'h2, "R7 mask partial");
        byte_mask = 4'hF;

        // R9 back-pressure
        fmt_code = 4'd13;
        out_ready = 1'b0;
        base = cap_n;
        send(32'h01020304, 1'b0);
        fork
            send(32'h05060708, 1'b1);
            begin
                idle(3);
                chk(out_valid == 1'b1, "R9 valid held", {31'b0, out_valid}, 1);
                chk(out_data == 32'h01020304, "R9 data held", out_data, 32'h01020304);
                chk(in_ready == 1'b0, "R9 input stalled", {31'b0, in_ready}, 0);
                @(posedge clk); #1 out_ready = 1'b1;
            end
        join
        idle(4);
        chk(cap_n == base + 2, "R9 count", cap_n - base, 2);
        expect_word(base,     32'h01020304, 4'hF, "R9 first");
        expect_word(base + 1, 32'h05060708, 4'hF, "R9 second");

        // R10 unused codes drop pixels
        fmt_code = 4'd5;
        idle(1);
        chk(fmt_err == 1'b1, "R10 fmt_err", {31'b0, fmt_err}, 1);
        base = cap_n;
        send(32'h11111111, 1'b0);
        send(32'h22222222, 1'b1);
        fmt_code = 4'd11;
        send(32'h33333333, 1'b1);
        idle(4);
        chk(cap_n == base, "R10 no words", cap_n - base, 0);
        fmt_code = 4'd13;
        send(32'hC35A962D, 1'b1);
        idle(4);
        chk(cap_n == base + 1, "R10 recovery count", cap_n - base, 1);
        expect_word(base, 32'hC35A962D, 4'hF, "R10 recovery");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule